// File: doc/BRIEF.md
# Per-Channel Idle Code Inserter

This block sits in the transmit path of a framed T1 or E1 serial stream. On selected timeslots it replaces the backplane data with an 8-bit idle code that the host has programmed. The host reaches a 64-entry code store indirectly. It first writes a pointer, then reads or writes a data register.

Entries 0–31 hold the transmit codes: entry n belongs to channel n+1. Entries 32–63 hold receive codes, which are only stored and read back. Two flag bits in the pointer register turn one data write into a fill of a whole half. A 32-bit enable bitmap, split into four byte registers, chooses which transmit channels are replaced.

The serial side counts bit positions from a frame sync. Each stream bit is qualified by a bit enable. The output is registered with one bit-enable cycle of latency. Any code or enable change made by the host applies from the next timeslot boundary onward, so a byte on the line is never split.

Top module: `idle_code_inserter`

## Requirements
- R1: After synchronous reset every host register reads 0, every code entry is 0, every channel is disabled and tx_out is 0.
- R2: Host offset 0 is the pointer register. Bits 5:0 are the entry pointer, bit 6 is the transmit-fill flag and bit 7 is the receive-fill flag. It reads back exactly as written.
- R3: With both fill flags clear, a write to offset 1 stores the byte in the entry the pointer selects. A read of offset 1 returns that entry, and no other entry changes.
- R4: With bit 6 of offset 0 set, one write to offset 1 loads the byte into all entries 0–31, whatever the pointer holds. Entries 32–63 keep their values.
- R5: With bit 7 of offset 0 set, one write to offset 1 loads the byte into all entries 32–63. Entries 0–31 keep their values.
- R6: Offsets 2, 3, 4 and 5 are the enable bytes, read back as written. Bit j of offset 2+k enables channel 8k+j+1, so bit 0 of offset 2 is channel 1.
- R7: In E1 mode (e1_mode=1), a bit with bit_en and fsync both high is the MSB of timeslot 0, which is channel 1, and a frame has 256 bits. For an enabled channel, the 8 bits are replaced by entry ch-1, MSB first.
- R8: In T1 mode (e1_mode=0), the bit marked by fsync is the framing bit. It is always passed through. It is followed by channels 1–24 of 8 bits each, and a frame has 193 bits.
- R9: Bits of a disabled channel leave unchanged. Receive entries never appear on tx_out.
- R10: tx_out takes the result for a bit on the clock edge that samples bit_en high. It holds its value while bit_en is low.
- R11: A code or enable write that lands inside a timeslot leaves the rest of that timeslot unchanged. It applies from the next timeslot of that channel.
- R12: Without fsync, the position keeps counting and wraps at the frame length, so later frames stay aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| e1_mode | input | 1 | 1 = E1 32-slot frame, 0 = T1 193-bit frame |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr (combinational) |
| bit_en | input | 1 | Qualifies one stream bit in this cycle |
| fsync | input | 1 | With bit_en, marks the first bit of a frame |
| tx_in | input | 1 | Backplane serial data |
| tx_out | output | 1 | Line serial data, one bit_en cycle late |

## Verification
If the position counter is off, substituted bytes appear in the wrong timeslot or rotated within the byte. This shows on tx_out one bit_en cycle after the faulty bit. A stale or early snapshot of a channel's code or enable shows as a timeslot split between the old and new codes, right after a write made mid-slot. A wrong write decode in the code store shows up when offset 1 is read back, or as a changed code in the next frame.

// File: rtl/idle_pkg.sv
package idle_pkg;

    localparam int CODE_W  = 8;
    localparam int NUM_CH  = 32;
    localparam int ENTRIES = 2 * NUM_CH;
    localparam int PTR_W   = $clog2(ENTRIES);
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int BIT_W   = $clog2(CODE_W);
    localparam int POS_W   = CH_W + BIT_W;
    localparam int E1_LAST = NUM_CH * CODE_W - 1;
    localparam int T1_CH   = 24;
    localparam int T1_LAST = T1_CH * CODE_W;
    localparam int EN_REGS = NUM_CH / 8;

    typedef enum logic [2:0] {
        OFS_PTR  = 3'd0,
        OFS_CODE = 3'd1,
        OFS_EN0  = 3'd2,
        OFS_EN1  = 3'd3,
        OFS_EN2  = 3'd4,
        OFS_EN3  = 3'd5
    } host_ofs_e;

    typedef struct packed {
        logic             fill_rx;
        logic             fill_tx;
        logic [PTR_W-1:0] ptr;
    } ptr_reg_t;

    typedef struct packed {
        logic             framing;
        logic [CH_W-1:0]  ch;
        logic [BIT_W-1:0] bitn;
    } slot_t;

    function automatic slot_t decode_pos(input logic e1, input logic [POS_W-1:0] pos);
        slot_t            s;
        logic [POS_W-1:0] adj;
        adj       = e1 ? pos : pos - 1'b1;
        s.framing = !e1 && (pos == '0);
        s.ch      = adj[POS_W-1:BIT_W];
        s.bitn    = adj[BIT_W-1:0];
        return s;
    endfunction

endpackage

// File: rtl/idle_host_regs.sv
module idle_host_regs
    import idle_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_we,
    input  logic [2:0]            host_addr,
    input  logic [CODE_W-1:0]     host_wdata,
    output ptr_reg_t              ptr_q,
    output logic [NUM_CH-1:0]     en_q,
    output logic                  code_we
);

    assign code_we = host_we && (host_addr == OFS_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (host_we && host_addr == OFS_PTR) begin
            ptr_q <= ptr_reg_t'(host_wdata);
        end
    end

    for (genvar k = 0; k < EN_REGS; k++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[k*8 +: 8] <= '0;
            end else if (host_we && host_addr == 3'(OFS_EN0 + k)) begin
                en_q[k*8 +: 8] <= host_wdata;
            end
        end
    end

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        host_we && host_addr == OFS_PTR |=> ptr_q == $past(host_wdata));

    // R6
    en_low_byte_chk: assert property (@(posedge clk) disable iff (rst)
        host_we && host_addr == OFS_EN0 |=> en_q[7:0] == $past(host_wdata));

endmodule

// File: rtl/idle_code_array.sv
module idle_code_array
    import idle_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [CODE_W-1:0]     wdata,
    input  ptr_reg_t              ptr_q,
    input  logic [CH_W-1:0]       tx_ch,
    output logic [CODE_W-1:0]     host_code,
    output logic [CODE_W-1:0]     tx_code
);

    logic [CODE_W-1:0] mem [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        localparam bit RX_HALF = (i >= NUM_CH);
        logic hit;
        assign hit = we && ((ptr_q.fill_tx && !RX_HALF) ||
                            (ptr_q.fill_rx &&  RX_HALF) ||
                            (!ptr_q.fill_tx && !ptr_q.fill_rx && ptr_q.ptr == PTR_W'(i)));
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (hit) begin
                mem[i] <= wdata;
            end
        end
    end

    assign host_code = mem[ptr_q.ptr];
    assign tx_code   = mem[{1'b0, tx_ch}];

    // R4
    fill_tx_chk: assert property (@(posedge clk) disable iff (rst)
        we && ptr_q.fill_tx |=> mem[0] == $past(wdata) && mem[NUM_CH-1] == $past(wdata));

    // R5
    fill_rx_chk: assert property (@(posedge clk) disable iff (rst)
        we && ptr_q.fill_rx |=> mem[NUM_CH] == $past(wdata) && mem[ENTRIES-1] == $past(wdata));

    // R3
    single_write_chk: assert property (@(posedge clk) disable iff (rst)
        we && !ptr_q.fill_tx && !ptr_q.fill_rx |=> mem[$past(ptr_q.ptr)] == $past(wdata));

endmodule

// File: rtl/idle_frame_timer.sv
module idle_frame_timer
    import idle_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  e1_mode,
    input  logic  bit_en,
    input  logic  fsync,
    output slot_t slot
);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] cur_pos;
    logic [POS_W-1:0] last_pos;

    assign cur_pos  = fsync ? '0 : pos_q;
    assign last_pos = e1_mode ? POS_W'(E1_LAST) : POS_W'(T1_LAST);
    assign slot     = decode_pos(e1_mode, cur_pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (bit_en) begin
            pos_q <= (cur_pos == last_pos) ? '0 : cur_pos + 1'b1;
        end
    end

    // R7
    sync_restart_chk: assert property (@(posedge clk) disable iff (rst)
        bit_en && fsync |=> pos_q == POS_W'(1));

    // R10
    hold_pos_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(pos_q));

endmodule

// File: rtl/idle_code_inserter.sv
module idle_code_inserter
    import idle_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 e1_mode,
    input  logic                 host_we,
    input  logic [2:0]           host_addr,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    input  logic                 bit_en,
    input  logic                 fsync,
    input  logic                 tx_in,
    output logic                 tx_out
);

    ptr_reg_t          ptr_q;
    logic [NUM_CH-1:0] en_q;
    logic              code_we;
    logic [CODE_W-1:0] host_code;
    logic [CODE_W-1:0] live_code;
    slot_t             slot;

    logic [CODE_W-1:0] snap_code;
    logic              snap_en;
    logic [CODE_W-1:0] use_code;
    logic              use_en;
    logic              first_bit;

    idle_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .ptr_q      (ptr_q),
        .en_q       (en_q),
        .code_we    (code_we)
    );

    idle_code_array u_array (
        .clk       (clk),
        .rst       (rst),
        .we        (code_we),
        .wdata     (host_wdata),
        .ptr_q     (ptr_q),
        .tx_ch     (slot.ch),
        .host_code (host_code),
        .tx_code   (live_code)
    );

    idle_frame_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .e1_mode (e1_mode),
        .bit_en  (bit_en),
        .fsync   (fsync),
        .slot    (slot)
    );

    always_comb begin
        case (host_addr)
            OFS_PTR:  host_rdata = ptr_q;
            OFS_CODE: host_rdata = host_code;
            OFS_EN0:  host_rdata = en_q[7:0];
            OFS_EN1:  host_rdata = en_q[15:8];
            OFS_EN2:  host_rdata = en_q[23:16];
            OFS_EN3:  host_rdata = en_q[31:24];
            default:  host_rdata = '0;
        endcase
    end

    // First bit of a timeslot samples live state; later bits use the snapshot.
    assign first_bit = (slot.bitn == '0);
    assign use_en    = first_bit ? en_q[slot.ch] : snap_en;
    assign use_code  = first_bit ? live_code     : snap_code;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_code <= '0;
            snap_en   <= 1'b0;
            tx_out    <= 1'b0;
        end else if (bit_en) begin
            if (first_bit && !slot.framing) begin
                snap_code <= live_code;
                snap_en   <= en_q[slot.ch];
            end
            tx_out <= (!slot.framing && use_en) ? use_code[3'd7 - slot.bitn] : tx_in;
        end
    end

    // R8
    framing_pass_chk: assert property (@(posedge clk) disable iff (rst)
        bit_en && slot.framing |=> tx_out == $past(tx_in));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx_out));

    // R11
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bit_en && !first_bit |=> $stable(snap_code) && $stable(snap_en));

endmodule

// File: tb/idle_code_inserter_test.sv
module idle_code_inserter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       e1_mode = 1'b1;
    logic       host_we = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       bit_en = 1'b0;
    logic       fsync = 1'b0;
    logic       tx_in = 1'b0;
    logic       tx_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0]  m_code [64];
    logic [31:0] m_en;
    logic [7:0]  m_ptr;
    logic [15:0] lf = 16'hACE1;

    always #5 clk = ~clk;

    idle_code_inserter uut (
        .clk(clk), .rst(rst), .e1_mode(e1_mode),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .bit_en(bit_en), .fsync(fsync),
        .tx_in(tx_in), .tx_out(tx_out)
    );

    // {we, offset, data, expected read}
    localparam int NV = 39;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 3'd0, 8'h00, 8'h00},  // R1
        {1'b0, 3'd2, 8'h00, 8'h00},  // R1
        {1'b0, 3'd3, 8'h00, 8'h00},  // R1
        {1'b0, 3'd4, 8'h00, 8'h00},  // R1
        {1'b0, 3'd5, 8'h00, 8'h00},  // R1
        {1'b1, 3'd0, 8'h05, 8'h00},  // R2
        {1'b0, 3'd0, 8'h00, 8'h05},  // R2
        {1'b1, 3'd1, 8'hA5, 8'h00},  // R3
        {1'b0, 3'd1, 8'h00, 8'hA5},  // R3
        {1'b1, 3'd0, 8'h06, 8'h00},  // R3
        {1'b0, 3'd1, 8'h00, 8'h00},  // R3 neighbour untouched
        {1'b1, 3'd0, 8'h25, 8'h00},  // R3 receive entry
        {1'b1, 3'd1, 8'h3C, 8'h00},  // R3
        {1'b0, 3'd1, 8'h00, 8'h3C},  // R3
        {1'b1, 3'd0, 8'h05, 8'h00},  // R3
        {1'b0, 3'd1, 8'h00, 8'hA5},  // R3
        {1'b1, 3'd0, 8'h45, 8'h00},  // R4 fill transmit half
        {1'b1, 3'd1, 8'h77, 8'h00},  // R4
        {1'b1, 3'd0, 8'h1F, 8'h00},  // R4
        {1'b0, 3'd1, 8'h00, 8'h77},  // R4
        {1'b1, 3'd0, 8'h00, 8'h00},  // R4
        {1'b0, 3'd1, 8'h00, 8'h77},  // R4
        {1'b1, 3'd0, 8'h25, 8'h00},  // R4
        {1'b0, 3'd1, 8'h00, 8'h3C},  // R4 receive half kept
        {1'b1, 3'd0, 8'hA0, 8'h00},  // R5 fill receive half
        {1'b1, 3'd1, 8'h99, 8'h00},  // R5
        {1'b1, 3'd0, 8'h3F, 8'h00},  // R5
        {1'b0, 3'd1, 8'h00, 8'h99},  // R5
        {1'b1, 3'd0, 8'h25, 8'h00},  // R5
        {1'b0, 3'd1, 8'h00, 8'h99},  // R5
        {1'b1, 3'd0, 8'h05, 8'h00},  // R5
        {1'b0, 3'd1, 8'h00, 8'h77},  // R5 transmit half kept
        {1'b1, 3'd0, 8'hC3, 8'h00},  // R2 both flags read back
        {1'b0, 3'd0, 8'h00, 8'hC3},  // R2
        {1'b1, 3'd2, 8'h81, 8'h00},  // R6
        {1'b0, 3'd2, 8'h00, 8'h81},  // R6
        {1'b1, 3'd5, 8'h7E, 8'h00},  // R6
        {1'b0, 3'd5, 8'h00, 8'h7E},  // R6
        {1'b0, 3'd3, 8'h00, 8'h00}   // R6
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 64; i++) m_code[i] = 8'h00;
        m_en  = '0;
        m_ptr = '0;
    endfunction

    function automatic void model_write(input logic [2:0] a, input logic [7:0] d);
        case (a)
            3'd0: m_ptr = d;
            3'd1: begin
                if (!m_ptr[6] && !m_ptr[7]) m_code[m_ptr[5:0]] = d;
                for (int i = 0; i < 64; i++)
                    if ((m_ptr[6] && i < 32) || (m_ptr[7] && i >= 32)) m_code[i] = d;
            end
            3'd2: m_en[7:0]   = d;
            3'd3: m_en[15:8]  = d;
            3'd4: m_en[23:16] = d;
            3'd5: m_en[31:24] = d;
            default: ;
        endcase
    endfunction

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic host_check(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        host_addr = a;
        #1;
        check(host_rdata == exp, req, host_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_en = 1'b0; fsync = 1'b0; host_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // One frame; optional host write landing on bit position wpos.
    task automatic run_frame(input bit e1, input bit sync, input int gap, input int wpos,
                             input logic [2:0] waddr, input logic [7:0] wdata);
        int         len = e1 ? 256 : 193;
        logic [7:0] s_code = 8'h00;
        bit         s_en = 1'b0;
        bit         exp;
        logic       last;
        string      req;
        e1_mode = e1;
        for (int p = 0; p < len; p++) begin
            int ch;
            int b;
            bit framing;
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            bit_en = 1'b1;
            fsync  = sync && (p == 0);
            tx_in  = lf[0];
            framing = !e1 && (p == 0);
            ch = e1 ? p / 8 : (p - 1) / 8;
            b  = e1 ? p % 8 : (p - 1) % 8;
            if (!framing && b == 0) begin
                s_code = m_code[ch];
                s_en   = m_en[ch];
            end
            if (framing) begin
                exp = tx_in; req = "R8";
            end else if (s_en) begin
                exp = s_code[7 - b]; req = sync ? "R7" : "R12";
            end else begin
                exp = tx_in; req = "R9";
            end
            if (wpos >= 0 && b >= 1 && p >= wpos && p < wpos + 8) req = "R11";
            if (p == wpos) begin
                host_we = 1'b1; host_addr = waddr; host_wdata = wdata;
            end
            @(posedge clk);
            #1;
            host_we = 1'b0;
            if (p == wpos) model_write(waddr, wdata);
            check(tx_out == exp, req, tx_out, exp);
            last = tx_out;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                bit_en = 1'b0; fsync = 1'b0; tx_in = ~tx_in;
                @(posedge clk);
                #1;
                check(tx_out == last, "R10", tx_out, last);
            end
        end
        @(negedge clk);
        bit_en = 1'b0; fsync = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(tx_out == 1'b0, "R1", tx_out, 0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][19]) host_write(VEC[v][18:16], VEC[v][15:8]);
            else            host_check(VEC[v][18:16], VEC[v][7:0], $sformatf("vector %0d", v));
        end

        do_reset();
        host_check(3'd1, 8'h00, "R1");
        for (int c = 0; c < 32; c++) begin
            host_write(3'd0, 8'(c));
            host_write(3'd1, 8'(8'h11 + c * 7));
        end
        host_write(3'd0, 8'hA0);
        host_write(3'd1, 8'hFF);     // R9 receive codes never sent
        host_write(3'd0, 8'h00);
        host_write(3'd2, 8'hA5);
        host_write(3'd3, 8'h0F);
        host_write(3'd4, 8'hF0);
        host_write(3'd5, 8'h81);

        run_frame(1'b1, 1'b1, 0, -1, 3'd0, 8'h00);   // R7
        run_frame(1'b1, 1'b0, 0, -1, 3'd0, 8'h00);   // R12
        run_frame(1'b1, 1'b1, 2, -1, 3'd0, 8'h00);   // R10

        host_write(3'd0, 8'h02);
        run_frame(1'b1, 1'b1, 0, 19, 3'd1, 8'h3C);   // R11 code write mid-slot
        run_frame(1'b1, 1'b1, 0, 5, 3'd2, 8'h5A);    // R11 enable write mid-slot
        run_frame(1'b1, 1'b1, 0, -1, 3'd0, 8'h00);

        run_frame(1'b0, 1'b1, 0, -1, 3'd0, 8'h00);   // R8
        run_frame(1'b0, 1'b0, 0, -1, 3'd0, 8'h00);   // R12
        run_frame(1'b0, 1'b1, 1, -1, 3'd0, 8'h00);   // R10

        host_write(3'd0, 8'h40);
        host_write(3'd1, 8'hC3);                     // R4 on the line
        host_write(3'd2, 8'hFF);
        run_frame(1'b1, 1'b1, 0, -1, 3'd0, 8'h00);
        host_write(3'd0, 8'h25);
        host_check(3'd1, 8'hFF, "R5");

        finish_run();
    end

endmodule